// File: doc/BRIEF.md
# Parallel Nibble-Mode Reverse Receiver

This host-side block collects bytes that a peripheral sends back over the four status data inputs of a standard parallel port. No extra data lines are used. A fifth status input carries the peripheral's active-low strobe. Each byte arrives as two 4-bit transfers. The first transfer carries the low half and the second carries the high half. Each transfer is framed by an interlocked handshake: the host raises a request, the peripheral pulls its strobe low, the host takes the nibble and drops its request, and the peripheral releases the strobe.

All port inputs pass through a synchronizer. The handshake advances only on cycles where the port clock-enable is high, so a fast core clock can pace a slow port. A finished byte is held on a valid/ready output until downstream logic takes it. No new byte is requested while that output is occupied. A handshake phase that stalls longer than a programmable number of port ticks is abandoned, any half-built byte is dropped, and a one-cycle error pulse is raised.

Top module: `nib_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `host_req`, `rx_valid` and `abort_err` are all 0.
- R2: A byte delivered on `rx_data` is {second nibble, first nibble}: the first nibble taken lands in bits 3:0 and the second in bits 7:4.
- R3: `rx_valid` stays 0 after only the first nibble of a byte has been taken. It rises only once the second nibble has been latched.
- R4: After `periph_ack_n` is seen low, `host_req` goes low. It does not rise again while `periph_ack_n` stays low.
- R5: While `rx_valid` is 1 and `rx_ready` is 0, `rx_data` holds steady and no new byte is requested (`host_req` stays 0). No received byte is overwritten or lost.
- R6: If `periph_ack_n` does not move for `tmo_limit` port ticks while the host waits on it, the transfer aborts. `abort_err` pulses high for one cycle and the partial byte is discarded, so the next byte is built from two fresh nibbles.
- R7: A `tmo_limit` of 0 disables the timeout: the host waits indefinitely and `abort_err` never pulses.
- R8: The handshake advances only on cycles with `port_tick` high. With `port_tick` held at 0, `host_req` never rises. Bytes are received correctly with sparse ticks.
- R9: After an abort, `host_req` stays low until `periph_ack_n` has returned high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| port_tick | input | 1 | Parallel-port clock-enable; the handshake steps only when high |
| tmo_limit | input | TMO_W | Stall limit in port ticks; 0 disables the timeout |
| stat_nib | input | 4 | Four status inputs carrying nibble data |
| periph_ack_n | input | 1 | Peripheral strobe, active low |
| host_req | output | 1 | Host request: high when the host is ready for a nibble |
| rx_data | output | 8 | Assembled byte |
| rx_valid | output | 1 | `rx_data` holds a byte |
| rx_ready | input | 1 | Downstream accepts the byte |
| abort_err | output | 1 | One-cycle pulse when a stalled transfer is abandoned |

## Verification
The bench drives nibble patterns with all-zero, all-one and alternating halves. A receiver that swapped the halves would return mirrored bytes. The bench stops after one nibble and checks that no byte is offered early. It holds a finished byte unaccepted and checks that the host neither requests nor changes the data, which is where an overwrite would appear. It holds the strobe low past the request drop to catch a host that re-requests too soon. It stalls in each handshake phase with a timeout set, and then checks that the next byte contains no leftover nibble from the abandoned one. A zero limit and sparse port ticks are also exercised, to expose a timeout that cannot be switched off or a handshake that runs on the core clock.

// File: rtl/nib_rx_pkg.sv
package nib_rx_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_REL   = 2'd2,
        ST_DRAIN = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } byte_slot_t;

    function automatic logic [BYTE_W-1:0] join_nibbles(
        input logic [NIB_W-1:0] lo,
        input logic [NIB_W-1:0] hi
    );
        return {hi, lo};
    endfunction

endpackage

// File: rtl/nib_rx_sync.sv
module nib_rx_sync #(
    parameter int          WIDTH   = 5,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else     chain[s] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/nib_rx_timer.sv
module nib_rx_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic             clr,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr || !en) cnt <= '0;
        else if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Expires on the limit-th tick spent waiting in one phase.
    assign expired = en && tick && (limit != '0) && (cnt >= limit - 1'b1);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt == '0);
endmodule

// File: rtl/nib_rx_buf.sv
module nib_rx_buf
    import nib_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              ready,
    output logic              valid,
    output logic [BYTE_W-1:0] data
);
    byte_slot_t slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (load) begin
            slot.valid <= 1'b1;
            slot.data  <= load_data;
        end else if (slot.valid && ready) begin
            slot.valid <= 1'b0;
        end
    end

    assign valid = slot.valid;
    assign data  = slot.data;

    assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (rst)
        load |-> !slot.valid);
    assert_hold_data_R5: assert property (@(posedge clk) disable iff (rst)
        (slot.valid && !ready) |=> (slot.valid && $stable(slot.data)));
endmodule

// File: rtl/nib_rx.sv
module nib_rx
    import nib_rx_pkg::*;
#(
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_tick,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic [3:0]       stat_nib,
    input  logic             periph_ack_n,
    output logic             host_req,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             abort_err
);
    localparam int IN_W = NIB_W + 1;

    logic [IN_W-1:0]   sync_q;
    logic              ack_s;
    logic [NIB_W-1:0]  nib_s;

    nib_rx_sync #(
        .WIDTH   (IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({1'b1, {NIB_W{1'b0}}})
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({periph_ack_n, stat_nib}),
        .d_out (sync_q)
    );

    assign ack_s = sync_q[IN_W-1];
    assign nib_s = sync_q[NIB_W-1:0];

    rx_state_e         state_q, state_d;
    logic              hi_q, hi_d;
    logic [NIB_W-1:0]  lo_q, lo_d;
    logic              load, abort, expired, waiting, advance;
    logic              err_q;

    assign waiting = (state_q == ST_REQ) || (state_q == ST_REL);
    assign advance = (state_d != state_q);

    nib_rx_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (port_tick),
        .en      (waiting),
        .clr     (advance),
        .limit   (tmo_limit),
        .expired (expired)
    );

    nib_rx_buf u_buf (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (join_nibbles(lo_q, nib_s)),
        .ready     (rx_ready),
        .valid     (rx_valid),
        .data      (rx_data)
    );

    always_comb begin
        state_d = state_q;
        hi_d    = hi_q;
        lo_d    = lo_q;
        load    = 1'b0;
        abort   = 1'b0;
        if (port_tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    // A new byte starts only when the output slot is free.
                    if (hi_q || !rx_valid) state_d = ST_REQ;
                end
                ST_REQ: begin
                    if (!ack_s) begin
                        if (hi_q) begin
                            load = 1'b1;
                            hi_d = 1'b0;
                        end else begin
                            lo_d = nib_s;
                            hi_d = 1'b1;
                        end
                        state_d = ST_REL;
                    end else if (expired) begin
                        abort   = 1'b1;
                        hi_d    = 1'b0;
                        state_d = ST_DRAIN;
                    end
                end
                ST_REL: begin
                    if (ack_s) begin
                        state_d = ST_IDLE;
                    end else if (expired) begin
                        abort   = 1'b1;
                        hi_d    = 1'b0;
                        state_d = ST_DRAIN;
                    end
                end
                default: begin
                    if (ack_s) state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hi_q    <= 1'b0;
            lo_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            hi_q    <= hi_d;
            lo_q    <= lo_d;
            err_q   <= abort;
        end
    end

    assign host_req  = (state_q == ST_REQ);
    assign abort_err = err_q;

    assert_req_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (host_req && !hi_q) |-> !rx_valid);
    assert_ack_interlock_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REL && !ack_s) |=> !host_req);
    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        abort_err |-> !host_req);
    assert_tmo_enabled_R7: assert property (@(posedge clk) disable iff (rst)
        abort_err |-> $past(tmo_limit) != '0);
    assert_tick_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !port_tick |=> $stable(state_q));
endmodule

// File: tb/nib_rx_bench.sv
module nib_rx_bench;
    localparam int TMO_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             port_tick;
    logic [TMO_W-1:0] tmo_limit = '0;
    logic [3:0]       stat_nib = '0;
    logic             periph_ack_n = 1'b1;
    logic             host_req;
    logic [7:0]       rx_data;
    logic             rx_valid;
    logic             rx_ready = 1'b0;
    logic             abort_err;

    int n_checks = 0;
    int n_fail   = 0;
    int err_cnt  = 0;
    int cyc      = 0;
    logic tick_off = 1'b1;
    logic sparse   = 1'b0;
    logic [1:0] div = '0;

    always #5 clk = ~clk;

    nib_rx #(.TMO_W(TMO_W)) u_nib_rx (
        .clk          (clk),
        .rst          (rst),
        .port_tick    (port_tick),
        .tmo_limit    (tmo_limit),
        .stat_nib     (stat_nib),
        .periph_ack_n (periph_ack_n),
        .host_req     (host_req),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_ready     (rx_ready),
        .abort_err    (abort_err)
    );

    always @(negedge clk) div <= div + 1'b1;
    assign port_tick = tick_off ? 1'b0 : (sparse ? (div == 2'd0) : 1'b1);

    always @(posedge clk) if (!rst && abort_err) err_cnt <= err_cnt + 1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung (actual=%0d cycles, expected<150000)", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_req(input logic v);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (host_req == v) return;
        end
        check(1'b0, "R4 host_req wait", int'(host_req), int'(v));
    endtask

    task automatic send_nib(input logic [3:0] nib);
        wait_req(1'b1);
        stat_nib     = nib;
        periph_ack_n = 1'b0;
        wait_req(1'b0);
        periph_ack_n = 1'b1;
    endtask

    task automatic take_byte(input logic [7:0] exp, input string req);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (rx_valid) break;
        end
        check(rx_valid && rx_data == exp, req, int'(rx_data), int'(exp));
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    // {first nibble, second nibble, expected byte}
    localparam logic [15:0] VEC [8] = '{
        16'h0_0_00, 16'hF_F_FF, 16'h5_A_A5, 16'hA_5_5A,
        16'hF_0_0F, 16'h0_F_F0, 16'hC_3_3C, 16'h1_8_81
    };

    initial begin
        int e0;
        // R1 reset state
        repeat (4) @(negedge clk);
        check(!host_req && !rx_valid && !abort_err, "R1 in reset",
              {host_req, rx_valid, abort_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!host_req && !rx_valid && !abort_err, "R1 after reset",
              {host_req, rx_valid, abort_err}, 0);
        // R8: no ticks, no request
        repeat (20) @(negedge clk);
        check(!host_req, "R8 no tick no request", int'(host_req), 0);
        tick_off = 1'b0;

        // R2 vector table
        for (int i = 0; i < 8; i++) begin
            send_nib(VEC[i][15:12]);
            send_nib(VEC[i][11:8]);
            take_byte(VEC[i][7:0], "R2 nibble order");
        end
        check(err_cnt == 0, "R7 no abort with limit 0", err_cnt, 0);

        // R3 one nibble only
        send_nib(4'h7);
        repeat (20) @(negedge clk);
        check(!rx_valid, "R3 no byte after first nibble", int'(rx_valid), 0);
        send_nib(4'hE);
        take_byte(8'hE7, "R3 byte after second nibble");

        // R5 hold-off
        send_nib(4'h4);
        send_nib(4'hB);
        repeat (30) @(negedge clk);
        check(!host_req, "R5 no request while full", int'(host_req), 0);
        check(rx_valid && rx_data == 8'hB4, "R5 data held", int'(rx_data), 'hB4);
        take_byte(8'hB4, "R5 held byte delivered");
        send_nib(4'h2);
        send_nib(4'hD);
        take_byte(8'hD2, "R5 next byte after release");

        // R4 ack held low past request drop
        wait_req(1'b1);
        stat_nib = 4'h9; periph_ack_n = 1'b0;
        wait_req(1'b0);
        repeat (20) @(negedge clk);
        check(!host_req, "R4 no request while ack low", int'(host_req), 0);
        periph_ack_n = 1'b1;
        send_nib(4'h6);
        take_byte(8'h69, "R4 byte after long ack");

        // R7 limit 0: wait forever
        e0 = err_cnt;
        wait_req(1'b1);
        repeat (200) @(negedge clk);
        check(err_cnt == e0 && host_req, "R7 timeout disabled", err_cnt - e0, 0);

        // R6 stall after first nibble (waiting in request phase)
        tmo_limit = 16'd8;
        send_nib(4'h3);
        e0 = err_cnt;
        repeat (60) @(negedge clk);
        check(err_cnt > e0, "R6 abort on request stall", err_cnt - e0, 1);
        check(!rx_valid, "R6 no byte after abort", int'(rx_valid), 0);
        tmo_limit = 16'd1000;
        send_nib(4'h6);
        send_nib(4'h9);
        take_byte(8'h96, "R6 partial nibble discarded");

        // R9 stall with ack stuck low (release phase)
        tmo_limit = 16'd8;
        wait_req(1'b1);
        stat_nib = 4'h5; periph_ack_n = 1'b0;
        e0 = err_cnt;
        wait_req(1'b0);
        repeat (60) @(negedge clk);
        check(err_cnt == e0 + 1, "R6 single abort pulse on ack stuck", err_cnt - e0, 1);
        check(!host_req, "R9 no request until ack high", int'(host_req), 0);
        tmo_limit = 16'd1000;
        periph_ack_n = 1'b1;
        send_nib(4'h1);
        send_nib(4'h2);
        take_byte(8'h21, "R9 fresh byte after abort");

        // R8 sparse ticks
        sparse = 1'b1;
        send_nib(4'hC);
        send_nib(4'h0);
        take_byte(8'h0C, "R8 sparse tick byte");
        send_nib(4'h8);
        send_nib(4'h7);
        take_byte(8'h78, "R8 sparse tick byte 2");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule